// File: doc/BRIEF.md
# PLL Reconfiguration Image Builder

This block turns three PLL divider settings into the 144-bit configuration image that a PLL's reconfiguration shift path expects. The settings are a feedback divider `m`, a reference pre-divider `n` and an output divider `c`, each 8 bits wide with a legal range of 1 to 255. A start pulse captures all three. Each divider is then split into half-period low and high counts, with an odd-duty flag and an automatic bypass flag, and placed in a fixed field layout. Constant charge-pump and loop-filter settings complete the image.

The finished image leaves the block as 18 bytes, one per clock, through a plain address/data/write-enable port. That port feeds a byte buffer owned by a downstream serializer. One cycle after the last byte, the block raises a single-cycle done pulse that tells the serializer to start shifting. Picking divider values and shifting the bits into the PLL are both handled elsewhere.

Top module: `pll_image_builder`

## Requirements
- R1: `m_i`, `n_i` and `c_i` are sampled on the clock edge that accepts a start pulse. Changing them after that edge has no effect on the bytes written in that run.
- R2: Each divider value d is encoded into four fields: low count = floor(d/2), high count = floor((d+1)/2), odd flag = d bit 0, and bypass = 1 exactly when d == 1.
- R3: The image holds seven 18-bit counter groups, starting at bit 0 in this order: C4, C3, C2, C1, C0, M, N. Inside a group, bits 7:0 are the low count, bit 8 is the odd flag, bits 16:9 are the high count and bit 17 is bypass. C0 encodes `c`, M encodes `m` and N encodes `n`.
- R4: Groups C1 through C4 have only their bypass bit set: each equals 18'h20000.
- R5: The field area above the groups holds constants:
  - bits 128:126 (charge-pump current) = 1
  - bits 133:129 = 0
  - bit 134 (VCO post-scale) = 0
  - bits 139:135 (loop-filter resistance) = 27
  - bits 141:140 (loop-filter capacitance) = 0
  - bits 143:142 = 0
- R6: Byte k carries image bits 8k+7 down to 8k, with bit 8k in data bit 0. Bytes go out at addresses 0 to 17 in ascending order, one per clock. `wr_en_o` is high for exactly 18 consecutive cycles, starting in the cycle after the start edge.
- R7: `done_o` is high for exactly one cycle, in the cycle right after byte 17 is written. `wr_en_o` is low during that cycle.
- R8: `busy_o` is high from the cycle after the start edge through the done cycle. It is low in the cycle after the done pulse.
- R9: A start pulse while `busy_o` is high, including during the done cycle, is ignored. It does not restart the run, does not re-capture the inputs and does not extend the sequence.
- R10: While `rst_n` is low, `busy_o`, `wr_en_o` and `done_o` are 0 and `wr_addr_o` is 0. A reset in the middle of a run returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; honoured only while idle |
| m_i | input | 8 | Feedback divider, 1..255 |
| n_i | input | 8 | Pre-divider, 1..255 |
| c_i | input | 8 | Output divider, 1..255 |
| busy_o | output | 1 | High while a run is in progress |
| wr_en_o | output | 1 | Byte write strobe to the buffer |
| wr_addr_o | output | 5 | Byte address, 0..17 |
| wr_data_o | output | 8 | Image byte for the current address |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench targets these corner cases:

- **Divider value 1.** A design that sets bypass on the wrong value, or computes the high count without the round-up, writes wrong bytes at the group boundaries.
- **Divider value 255.** A high count computed as (d+1)/2 in only 8 bits wraps to 0 instead of 128.
- **Odd/even mix.** A swapped low/high order or a misplaced odd flag shows up when the three dividers differ in parity.
- **Inputs changed after start.** A design that samples the inputs live instead of latching them writes the altered values.
- **Start while busy or in the done cycle.** A design that re-arms there restarts the address sequence or never drops `busy_o`.
- **Timing of done and write-enable.** An off-by-one in the counter writes 17 or 19 bytes, or moves the done pulse by one cycle.

// File: rtl/pllimg_pkg.sv
package pllimg_pkg;

    // Divider and counter-group geometry
    localparam int DIV_W    = 8;
    localparam int GRP_W    = 2 * DIV_W + 2;
    localparam int NUM_GRP  = 7;

    // Group slots from bit 0 upward
    localparam int G_C4 = 0;
    localparam int G_C3 = 1;
    localparam int G_C2 = 2;
    localparam int G_C1 = 3;
    localparam int G_C0 = 4;
    localparam int G_M  = 5;
    localparam int G_N  = 6;

    // Trailing constant-field widths
    localparam int CP_W   = 3;
    localparam int RSV0_W = 5;
    localparam int VPS_W  = 1;
    localparam int LFR_W  = 5;
    localparam int LFC_W  = 2;
    localparam int RSV1_W = 2;
    localparam int TAIL_W = CP_W + RSV0_W + VPS_W + LFR_W + LFC_W + RSV1_W;

    // Image and byte port geometry
    localparam int IMG_W     = NUM_GRP * GRP_W + TAIL_W;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = IMG_W / BYTE_W;
    localparam int ADDR_W    = $clog2(NUM_BYTES);

    // One counter group; bit 0 of the packed struct is low[0]
    typedef struct packed {
        logic             bypass;
        logic [DIV_W-1:0] high;
        logic             odd;
        logic [DIV_W-1:0] low;
    } grp_t;

    // Constant fields above the groups; bit 0 is cp[0]
    typedef struct packed {
        logic [RSV1_W-1:0] rsv1;
        logic [LFC_W-1:0]  lf_cap;
        logic [LFR_W-1:0]  lf_res;
        logic [VPS_W-1:0]  vco_ps;
        logic [RSV0_W-1:0] rsv0;
        logic [CP_W-1:0]   cp;
    } tail_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } st_e;

endpackage

// File: rtl/pllimg_field_enc.sv
module pllimg_field_enc
    import pllimg_pkg::*;
(
    input  logic [DIV_W-1:0] div_i,
    output grp_t             grp_o
);

    logic [DIV_W-1:0] half;

    always_comb begin
        half          = div_i >> 1;
        grp_o.low     = half;
        // Adding the odd bit avoids (d+1) overflowing at the top of the range
        grp_o.high    = half + {{(DIV_W-1){1'b0}}, div_i[0]};
        grp_o.odd     = div_i[0];
        grp_o.bypass  = (div_i == DIV_W'(1));
    end

    // R2: the two half-period counts together make up the divider
    always_comb begin
        if (div_i != '0) begin
            a_r2_split_sum: assert (({1'b0, grp_o.low} + {1'b0, grp_o.high}) == {1'b0, div_i})
                else $error("a_r2_split_sum: low+high != divider");
        end
    end

endmodule

// File: rtl/pllimg_packer.sv
module pllimg_packer
    import pllimg_pkg::*;
#(
    parameter logic [CP_W-1:0]  CP_VAL  = CP_W'(1),
    parameter logic [LFR_W-1:0] LFR_VAL = LFR_W'(27),
    parameter logic [LFC_W-1:0] LFC_VAL = LFC_W'(0)
) (
    input  logic [DIV_W-1:0] m_i,
    input  logic [DIV_W-1:0] n_i,
    input  logic [DIV_W-1:0] c_i,
    output logic [IMG_W-1:0] img_o
);

    localparam int TAIL_LSB = NUM_GRP * GRP_W;

    grp_t  grp [NUM_GRP];
    tail_t tail;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        if (g == G_C0) begin : g_c0
            pllimg_field_enc u_enc (.div_i(c_i), .grp_o(grp[g]));
        end else if (g == G_M) begin : g_m
            pllimg_field_enc u_enc (.div_i(m_i), .grp_o(grp[g]));
        end else if (g == G_N) begin : g_n
            pllimg_field_enc u_enc (.div_i(n_i), .grp_o(grp[g]));
        end else begin : g_unused
            // Unused output counters: bypassed, counts zero
            assign grp[g] = '{bypass: 1'b1, high: '0, odd: 1'b0, low: '0};
        end
        assign img_o[g*GRP_W +: GRP_W] = grp[g];
    end

    always_comb begin
        tail        = '0;
        tail.cp     = CP_VAL;
        tail.lf_res = LFR_VAL;
        tail.lf_cap = LFC_VAL;
    end

    assign img_o[TAIL_LSB +: TAIL_W] = tail;

endmodule

// File: rtl/pllimg_seq.sv
module pllimg_seq
    import pllimg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  m_i,
    input  logic [DIV_W-1:0]  n_i,
    input  logic [DIV_W-1:0]  c_i,
    output logic [DIV_W-1:0]  m_o,
    output logic [DIV_W-1:0]  n_o,
    output logic [DIV_W-1:0]  c_o,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_BYTES - 1);

    typedef struct packed {
        st_e              st;
        logic [ADDR_W-1:0] idx;
        logic [DIV_W-1:0]  m;
        logic [DIV_W-1:0]  n;
        logic [DIV_W-1:0]  c;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st  = ST_WRITE;
                    s_d.idx = '0;
                    s_d.m   = m_i;
                    s_d.n   = n_i;
                    s_d.c   = c_i;
                end
            end
            ST_WRITE: begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_DONE: begin
                s_d.st  = ST_IDLE;
                s_d.idx = '0;
            end
            default: begin
                s_d.st  = ST_IDLE;
                s_d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, idx: '0, m: '0, n: '0, c: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign m_o     = s_q.m;
    assign n_o     = s_q.n;
    assign c_o     = s_q.c;
    assign busy_o  = (s_q.st != ST_IDLE);
    assign wr_en_o = (s_q.st == ST_WRITE);
    assign addr_o  = s_q.idx;
    assign done_o  = (s_q.st == ST_DONE);

    // R1: captured dividers stay fixed for the whole run
    a_r1_hold_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(m_o) && $stable(n_o) && $stable(c_o)));

    // R6: a write step advances the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && addr_o != LAST_IDX) |=> (wr_en_o && addr_o == $past(addr_o) + 1'b1));

    // R6/R8: an accepted start begins writing at address 0
    a_r8_start_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && wr_en_o && addr_o == '0));

    // R7: done follows the last byte and lasts one cycle
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && addr_o == LAST_IDX) |=> (done_o && !wr_en_o));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R9: start during a run does not disturb the sequence
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && start_i && addr_o != LAST_IDX) |=> (wr_en_o && addr_o != '0));

    // R8: strobes only occur while busy
    a_r8_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || done_o) |-> busy_o);

endmodule

// File: rtl/pll_image_builder.sv
module pll_image_builder
    import pllimg_pkg::*;
#(
    parameter logic [CP_W-1:0]  CP_VAL  = CP_W'(1),
    parameter logic [LFR_W-1:0] LFR_VAL = LFR_W'(27),
    parameter logic [LFC_W-1:0] LFC_VAL = LFC_W'(0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  m_i,
    input  logic [DIV_W-1:0]  n_i,
    input  logic [DIV_W-1:0]  c_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              done_o
);

    logic [DIV_W-1:0]  m_cap, n_cap, c_cap;
    logic [IMG_W-1:0]  img;
    logic [BYTE_W-1:0] img_bytes [NUM_BYTES];

    pllimg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .m_i     (m_i),
        .n_i     (n_i),
        .c_i     (c_i),
        .m_o     (m_cap),
        .n_o     (n_cap),
        .c_o     (c_cap),
        .busy_o  (busy_o),
        .wr_en_o (wr_en_o),
        .addr_o  (wr_addr_o),
        .done_o  (done_o)
    );

    pllimg_packer #(
        .CP_VAL  (CP_VAL),
        .LFR_VAL (LFR_VAL),
        .LFC_VAL (LFC_VAL)
    ) u_packer (
        .m_i   (m_cap),
        .n_i   (n_cap),
        .c_i   (c_cap),
        .img_o (img)
    );

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        assign img_bytes[k] = img[k*BYTE_W +: BYTE_W];
    end

    always_comb begin
        wr_data_o = '0;
        if (32'(wr_addr_o) < NUM_BYTES) begin
            wr_data_o = img_bytes[wr_addr_o];
        end
    end

    // R6: the write address never leaves the buffer range
    a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (32'(wr_addr_o) < NUM_BYTES));

endmodule

// File: tb/pll_image_builder_test.sv
module pll_image_builder_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [7:0] m_i, n_i, c_i;
    logic       busy_o, wr_en_o, done_o;
    logic [4:0] wr_addr_o;
    logic [7:0] wr_data_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pll_image_builder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .m_i       (m_i),
        .n_i       (n_i),
        .c_i       (c_i),
        .busy_o    (busy_o),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .done_o    (done_o)
    );

    // {m, n, c}
    localparam int NVEC = 7;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd1,   8'd1,   8'd1},
        {8'd255, 8'd255, 8'd255},
        {8'd12,  8'd1,   8'd5},
        {8'd245, 8'd17,  8'd6},
        {8'd185, 8'd11,  8'd7},
        {8'd2,   8'd3,   8'd4},
        {8'd100, 8'd254, 8'd1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] grp(input logic [7:0] d);
        logic [8:0] up;
        up = ({1'b0, d} + 9'd1) >> 1;
        return {(d == 8'd1), up[7:0], d[0], d >> 1};
    endfunction

    function automatic logic [143:0] exp_img(input logic [7:0] m, input logic [7:0] n, input logic [7:0] c);
        logic [143:0] r;
        r = '0;
        for (int g = 0; g < 4; g++) r[g*18 + 17] = 1'b1;
        r[72  +: 18] = grp(c);
        r[90  +: 18] = grp(m);
        r[108 +: 18] = grp(n);
        r[126 +: 3]  = 3'd1;
        r[135 +: 5]  = 5'd27;
        return r;
    endfunction

    // One full run; disturb adds starts while busy and in the done cycle
    task automatic run_one(input logic [7:0] m, input logic [7:0] n, input logic [7:0] c, input bit disturb);
        logic [143:0] got, exp;
        exp = exp_img(m, n, c);
        got = '0;
        @(negedge clk);
        m_i = m; n_i = n; c_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R1: alter inputs after capture
        m_i = ~m; n_i = ~n; c_i = ~c;
        for (int k = 0; k < 18; k++) begin
            chk(wr_en_o == 1'b1, "R6 wr_en during write", 32'(wr_en_o), 32'd1);
            chk(wr_addr_o == 5'(k), "R6 address order", 32'(wr_addr_o), 32'(k));
            chk(busy_o == 1'b1 && done_o == 1'b0, "R8 busy/done while writing",
                32'({busy_o, done_o}), 32'b10);
            got[k*8 +: 8] = wr_data_o;
            start_i = (disturb && k == 5);
            @(negedge clk);
        end
        chk(done_o == 1'b1 && wr_en_o == 1'b0, "R7 done after byte 17", 32'({done_o, wr_en_o}), 32'b10);
        chk(busy_o == 1'b1, "R8 busy in done cycle", 32'(busy_o), 32'd1);
        start_i = disturb;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
        chk(busy_o == 1'b0 && wr_en_o == 1'b0, "R9 R8 idle after done", 32'({busy_o, wr_en_o}), 32'd0);
        for (int k = 0; k < 18; k++) begin
            chk(got[k*8 +: 8] == exp[k*8 +: 8], "R3 R6 image byte", 32'(got[k*8 +: 8]), 32'(exp[k*8 +: 8]));
        end
        chk(got[72 +: 8] == (c >> 1), "R2 C0 low count", 32'(got[72 +: 8]), 32'(c >> 1));
        chk(got[81 +: 8] == 8'((9'(c) + 9'd1) >> 1), "R2 C0 high count",
            32'(got[81 +: 8]), 32'((9'(c) + 9'd1) >> 1));
        chk(got[107] == (m == 8'd1), "R2 M bypass", 32'(got[107]), 32'(m == 8'd1));
        chk(got[116] == n[0], "R2 N odd flag", 32'(got[116]), 32'(n[0]));
        chk(got[71:0] == {4{18'h20000}}, "R4 C1-C4 bypass only", 32'(got[17:0]), 32'h20000);
        chk(got[143:126] == {2'd0, 2'd0, 5'd27, 1'b0, 5'd0, 3'd1}, "R5 constant fields",
            32'(got[143:126]), 32'({2'd0, 2'd0, 5'd27, 1'b0, 5'd0, 3'd1}));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; m_i = '0; n_i = '0; c_i = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({busy_o, wr_en_o, done_o} == 3'b000, "R10 reset outputs", 32'({busy_o, wr_en_o, done_o}), 32'd0);
        chk(wr_addr_o == 5'd0, "R10 reset address", 32'(wr_addr_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R8 idle without start", 32'(busy_o), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            run_one(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R9: starts while writing and in the done cycle are ignored
        run_one(8'd37, 8'd2, 8'd9, 1'b1);
        // back-to-back run right after the previous one
        run_one(8'd3, 8'd128, 8'd254, 1'b0);

        // R10: reset in the middle of a run
        @(negedge clk);
        m_i = 8'd20; n_i = 8'd2; c_i = 8'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy_o, wr_en_o, done_o} == 3'b000, "R10 mid-run reset", 32'({busy_o, wr_en_o, done_o}), 32'd0);
        chk(wr_addr_o == 5'd0, "R10 mid-run reset address", 32'(wr_addr_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_one(8'd64, 8'd5, 8'd2, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule